// File: doc/BRIEF.md
# Start-stop receive deframer

This block turns a recovered serial line into bytes. The line is sampled on a qualifying tick that runs at eight times the bit rate. In the start-stop modes the block finds a start bit, confirms it at mid-bit and gathers five to eight data bits, plus an optional parity bit. It then examines the stop position. In synchronous mode it simply packs every eight line bits into a byte. Each finished byte goes to a holding register, along with a framing-error flag and a flag that shows whether the character had even parity.

The parity is reported, not judged: the block has no parity setting. A missing stop bit raises a framing error, but the byte is still delivered, and the low level found at the stop position is taken as the start bit of the next character. An all-zero character is a break. It is flagged, and reception pauses until the line returns high and falls again. Two overspeed modes allow a limited number of missing stop bits without an error.

Top module: `rxd_deframer`

## Requirements
- R1: The format input selects the character length: bit 0 set means a parity bit follows the data, and bits 2:1 add 0 to 3 to a base of five data bits (000 = 5 data bits without parity, 111 = 8 data bits with parity). The first data bit received lands in bit 0 of the byte. Output bits above the selected length read as 0.
- R2: The parity flag is 1 when the data bits together with the parity bit (if present) hold an even number of ones, and 0 when they hold an odd number.
- R3: A falling edge on the line, seen on a tick after the line was high, starts a character only if the line is still low on the fourth tick after it. Otherwise it is ignored and nothing is delivered.
- R4: In mode 110 (no overspeed), a low stop position sets the framing error and the byte is still delivered. That low level serves as the start bit of the next character.
- R5: A character whose data, parity and stop positions are all low sets the framing error. No further character is taken until the line has been seen high and then falls.
- R6: Mode 100 accepts a missing stop bit without a framing error if at least 8 characters have passed since the last one accepted. Mode 101 does the same with 16. Mode selection starts either mode with the allowance available. A refused missing stop bit raises a framing error.
- R7: With mode bit 2 clear the receiver is off: nothing is delivered and the outputs hold.
- R8: Mode 111 is synchronous. The first line bit is taken on the fourth tick after the mode is selected, then one bit every eight ticks. Every eight bits form a byte, LSB first, with the framing error reported 0.
- R9: The data-ready output pulses for exactly one clock, two clock edges after the tick that samples the stop position (or the last synchronous bit). The byte and its flags become valid in the same cycle.
- R10: If a byte is delivered while the previous one is unread, the overflow flag sets and the new byte replaces the old one. A read strobe clears the overflow flag.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_en | input | 1 | Sample tick, eight per bit period |
| rx_line | input | 1 | Recovered serial line, idle high |
| rx_mode | input | 3 | 0xx off, 100/101 overspeed, 110 plain start-stop, 111 synchronous |
| rx_fmt | input | 3 | Data length and parity presence |
| rd_strb | input | 1 | Read of the holding register |
| data_out | output | 8 | Last delivered byte |
| data_rdy | output | 1 | One-cycle pulse per delivered byte |
| overflow | output | 1 | Byte was overwritten before being read |
| frm_err | output | 1 | Framing error of the last byte |
| par_even | output | 1 | Last character had even parity |

## Verification
A byte and its flags are due two clock edges after the tick that samples the stop position: one register sits in the frame engine and one in the holding register. The bench leaves the line in each bit slot for eight ticks, spaced two clocks apart, and reads the outputs on falling edges once the stop slot has ended. One directed test checks the data-ready pulse on the exact falling edges around that tick. The overflow flag clears one edge after the read strobe, and each read is followed by a falling-edge sample.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_HUNT,
      ST_START,
      ST_BITS,
      ST_STOP,
      ST_BRK,
      ST_SYNC
   } rx_state_t;

   // tolerance selector = mode[1:0] when mode[2] is set
   localparam logic [1:0] TOL_WIDE   = 2'b00;
   localparam logic [1:0] TOL_NARROW = 2'b01;
   localparam logic [1:0] TOL_NONE   = 2'b10;
   localparam logic [1:0] TOL_SYNC   = 2'b11;

   function automatic logic [3:0] data_len(input logic [2:0] f);
      return 4'd5 + {2'b00, f[2:1]};
   endfunction

   function automatic logic [3:0] frame_len(input logic [2:0] f);
      return data_len(f) + {3'b000, f[0]};
   endfunction

endpackage

// File: rtl/rxd_frame_fsm.sv
module rxd_frame_fsm
   import rxd_pkg::*;
#(
   parameter int OVS = 8,
   parameter int MID = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              rx_line,
   input  logic [2:0]        mode,
   input  logic [2:0]        fmt,
   output logic              restart_o,
   output logic              dv_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              miss_o,
   output logic              brk_o,
   output logic              even_o
);

   localparam int PH_W = (OVS > 2) ? $clog2(OVS) : 1;
   localparam logic [PH_W-1:0] PH_MID  = PH_W'(MID - 1);
   localparam logic [PH_W-1:0] PH_FULL = PH_W'(OVS - 1);
   localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);

   rx_state_t          st;
   logic [PH_W-1:0]    ph;
   logic [3:0]         bcnt;
   logic [BYTE_W-1:0]  sh;
   logic [BYTE_W-1:0]  aligned;
   logic [BYTE_W-1:0]  sync_byte;
   logic               pbit;
   logic               ones;
   logic               armed;
   logic [2:0]         mode_q;
   logic               restart;
   logic [3:0]         nd;
   logic [3:0]         nf;

   assign restart   = (mode != mode_q);
   assign restart_o = restart;
   assign nd        = data_len(fmt);
   assign nf        = frame_len(fmt);
   assign aligned   = sh >> (4'd8 - nd);
   assign sync_byte = {rx_line, sh[BYTE_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_OFF;
         ph     <= '0;
         bcnt   <= '0;
         sh     <= '0;
         pbit   <= 1'b0;
         ones   <= 1'b0;
         armed  <= 1'b0;
         mode_q <= 3'b000;
         dv_o   <= 1'b0;
         byte_o <= '0;
         miss_o <= 1'b0;
         brk_o  <= 1'b0;
         even_o <= 1'b0;
      end else begin
         dv_o   <= 1'b0;
         mode_q <= mode;
         if (restart) begin
            armed <= 1'b0;
            bcnt  <= '0;
            ph    <= PH_MID;
            if (!mode[2])              st <= ST_OFF;
            else if (mode[1:0] == TOL_SYNC) st <= ST_SYNC;
            else                       st <= ST_HUNT;
         end else if (samp_en) begin
            case (st)
               ST_HUNT: begin
                  if (rx_line) armed <= 1'b1;
                  else if (armed) begin
                     st <= ST_START;
                     ph <= PH_MID;
                  end
               end
               ST_START: begin
                  if (ph != '0) ph <= ph - PH_ONE;
                  else if (rx_line) begin
                     st    <= ST_HUNT;
                     armed <= 1'b1;
                  end else begin
                     st   <= ST_BITS;
                     ph   <= PH_FULL;
                     bcnt <= '0;
                     ones <= 1'b0;
                  end
               end
               ST_BITS: begin
                  if (ph != '0) ph <= ph - PH_ONE;
                  else begin
                     ph   <= PH_FULL;
                     ones <= ones | rx_line;
                     if (bcnt < nd) sh <= sync_byte;
                     else           pbit <= rx_line;
                     bcnt <= bcnt + 4'd1;
                     if (bcnt == nf - 4'd1) st <= ST_STOP;
                  end
               end
               ST_STOP: begin
                  if (ph != '0) ph <= ph - PH_ONE;
                  else begin
                     dv_o   <= 1'b1;
                     byte_o <= aligned;
                     even_o <= ~(^aligned ^ (fmt[0] & pbit));
                     miss_o <= !rx_line && ones;
                     brk_o  <= !rx_line && !ones;
                     bcnt   <= '0;
                     ones   <= 1'b0;
                     if (rx_line) begin
                        st    <= ST_HUNT;
                        armed <= 1'b1;
                     end else if (!ones) begin
                        st <= ST_BRK;
                     end else begin
                        st <= ST_BITS;
                        ph <= PH_FULL;
                     end
                  end
               end
               ST_BRK: begin
                  if (rx_line) begin
                     st    <= ST_HUNT;
                     armed <= 1'b1;
                  end
               end
               ST_SYNC: begin
                  if (ph != '0) ph <= ph - PH_ONE;
                  else begin
                     ph <= PH_FULL;
                     sh <= sync_byte;
                     if (bcnt == 4'd7) begin
                        bcnt   <= '0;
                        dv_o   <= 1'b1;
                        byte_o <= sync_byte;
                        even_o <= ~(^sync_byte);
                        miss_o <= 1'b0;
                        brk_o  <= 1'b0;
                     end else begin
                        bcnt <= bcnt + 4'd1;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R9: a delivery is a single-cycle event
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dv_o |=> !dv_o);

   // R3: a start that is high at mid-bit falls back to hunting
   a_r3_glitch_rejected: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_START && samp_en && ph == '0 && rx_line && !restart) |=> (st == ST_HUNT));

   // R7: a receiver that stays off delivers nothing
   a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[2] && !mode_q[2]) |=> !dv_o);

   // R5: after a break the engine waits while the line stays low
   a_r5_break_waits_high: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BRK && !rx_line && !restart) |=> (st == ST_BRK));

endmodule

// File: rtl/rxd_stop_budget.sv
module rxd_stop_budget
   import rxd_pkg::*;
#(
   parameter int WIN_WIDE   = 8,
   parameter int WIN_NARROW = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       restart,
   input  logic       dv,
   input  logic       miss,
   input  logic [1:0] tol,
   output logic       accept
);

   localparam int WMAX = (WIN_WIDE > WIN_NARROW) ? WIN_WIDE : WIN_NARROW;
   localparam int CW   = $clog2(WMAX + 1);

   logic [CW-1:0] since;
   logic [CW-1:0] need;
   logic          tol_on;

   assign need   = (tol == TOL_WIDE) ? CW'(WIN_WIDE) : CW'(WIN_NARROW);
   assign tol_on = (tol == TOL_WIDE) || (tol == TOL_NARROW);
   assign accept = dv && miss && tol_on && (since >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       since <= CW'(WMAX);
      else if (restart)                 since <= CW'(WMAX);
      else if (dv) begin
         if (accept)                    since <= CW'(1);
         else if (since != CW'(WMAX))   since <= since + CW'(1);
      end
   end

   // R6: two accepted misses are never closer than the narrower window
   a_r6_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !restart) |=> !accept);

endmodule

// File: rtl/rxd_hold_reg.sv
module rxd_hold_reg
   import rxd_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dv,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              ferr_i,
   input  logic              even_i,
   input  logic              rd,
   output logic [BYTE_W-1:0] data_o,
   output logic              ferr_o,
   output logic              par_o,
   output logic              rdy_o,
   output logic              ovf_o
);

   logic unread;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         ferr_o <= 1'b0;
         par_o  <= 1'b0;
         rdy_o  <= 1'b0;
         ovf_o  <= 1'b0;
         unread <= 1'b0;
      end else begin
         rdy_o <= dv;
         if (dv) begin
            data_o <= byte_i;
            ferr_o <= ferr_i;
            par_o  <= even_i;
            unread <= 1'b1;
            if (rd)          ovf_o <= 1'b0;
            else if (unread) ovf_o <= 1'b1;
         end else if (rd) begin
            unread <= 1'b0;
            ovf_o  <= 1'b0;
         end
      end
   end

   // R10: a read strobe always leaves overflow clear
   a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> !ovf_o);

   // R10: overflow only rises when an unread byte is replaced
   a_r10_rise_needs_unread: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> $past(unread));

endmodule

// File: rtl/rxd_deframer.sv
module rxd_deframer
   import rxd_pkg::*;
#(
   parameter int OVS        = 8,
   parameter int MID_SAMPLE = 4,
   parameter int WIN_WIDE   = 8,
   parameter int WIN_NARROW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              rx_line,
   input  logic [2:0]        rx_mode,
   input  logic [2:0]        rx_fmt,
   input  logic              rd_strb,
   output logic [BYTE_W-1:0] data_out,
   output logic              data_rdy,
   output logic              overflow,
   output logic              frm_err,
   output logic              par_even
);

   generate
      if (OVS < 4) begin : g_bad_ovs
         $error("rxd_deframer: OVS must be at least 4");
      end
      if (MID_SAMPLE < 1 || MID_SAMPLE >= OVS) begin : g_bad_mid
         $error("rxd_deframer: MID_SAMPLE must lie inside one bit period");
      end
      if (WIN_WIDE < 1 || WIN_NARROW < 1) begin : g_bad_win
         $error("rxd_deframer: tolerance windows must be positive");
      end
   endgenerate

   logic              restart;
   logic              dv;
   logic [BYTE_W-1:0] byte_w;
   logic              miss;
   logic              brk;
   logic              even;
   logic              accept;
   logic              ferr;

   rxd_frame_fsm #(.OVS(OVS), .MID(MID_SAMPLE)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_en   (samp_en),
      .rx_line   (rx_line),
      .mode      (rx_mode),
      .fmt       (rx_fmt),
      .restart_o (restart),
      .dv_o      (dv),
      .byte_o    (byte_w),
      .miss_o    (miss),
      .brk_o     (brk),
      .even_o    (even)
   );

   rxd_stop_budget #(.WIN_WIDE(WIN_WIDE), .WIN_NARROW(WIN_NARROW)) u_budget (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .dv      (dv),
      .miss    (miss),
      .tol     (rx_mode[1:0]),
      .accept  (accept)
   );

   assign ferr = brk | (miss & ~accept);

   rxd_hold_reg u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .dv     (dv),
      .byte_i (byte_w),
      .ferr_i (ferr),
      .even_i (even),
      .rd     (rd_strb),
      .data_o (data_out),
      .ferr_o (frm_err),
      .par_o  (par_even),
      .rdy_o  (data_rdy),
      .ovf_o  (overflow)
   );

   // R5: a break always reaches the framing-error output
   a_r5_break_is_error: assert property (@(posedge clk) disable iff (!rst_n)
      (dv && brk) |=> frm_err);

   // R9: each delivery shows up as data-ready one edge later
   a_r9_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
      dv |=> data_rdy);

endmodule

// File: tb/rxd_deframer_test.sv
`timescale 1ns/1ps
module rxd_deframer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_en = 1'b0;
   logic       rx_line = 1'b1;
   logic [2:0] rx_mode = 3'b000;
   logic [2:0] rx_fmt = 3'b110;
   logic       rd_strb = 1'b0;
   logic [7:0] data_out;
   logic       data_rdy, overflow, frm_err, par_even;

   int total = 0;
   int bad = 0;
   int rdy_cnt = 0;

   always #2 clk = ~clk;

   rxd_deframer uut (
      .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .rx_line(rx_line),
      .rx_mode(rx_mode), .rx_fmt(rx_fmt), .rd_strb(rd_strb),
      .data_out(data_out), .data_rdy(data_rdy), .overflow(overflow),
      .frm_err(frm_err), .par_even(par_even)
   );

   always @(posedge clk) if (data_rdy) rdy_cnt++;

   // fmt, sent data, parity bit, expected data, expected parity flag
   localparam logic [20:0] VEC [0:8] = '{
      {3'b110, 8'hA5, 1'b0, 8'hA5, 1'b1},
      {3'b111, 8'hA5, 1'b1, 8'hA5, 1'b0},
      {3'b000, 8'hF3, 1'b0, 8'h13, 1'b0},
      {3'b001, 8'h0B, 1'b1, 8'h0B, 1'b1},
      {3'b010, 8'h3C, 1'b0, 8'h3C, 1'b1},
      {3'b011, 8'h2A, 1'b0, 8'h2A, 1'b0},
      {3'b100, 8'h7F, 1'b0, 8'h7F, 1'b0},
      {3'b101, 8'h55, 1'b0, 8'h55, 1'b1},
      {3'b110, 8'h00, 1'b0, 8'h00, 1'b1}
   };

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input logic b);
      @(negedge clk);
      samp_en = 1'b1;
      rx_line = b;
      @(negedge clk);
      samp_en = 1'b0;
   endtask

   task automatic slot(input logic b);
      for (int i = 0; i < 8; i++) tick(b);
   endtask

   task automatic send(input logic [2:0] f, input logic [7:0] d, input logic p,
                       input logic with_start, input logic stop_v);
      int nd = 5 + int'(f[2:1]);
      rx_fmt = f;
      if (with_start) slot(1'b0);
      for (int i = 0; i < nd; i++) slot(d[i]);
      if (f[0]) slot(p);
      slot(stop_v);
   endtask

   task automatic rd_pulse();
      @(negedge clk);
      rd_strb = 1'b1;
      @(negedge clk);
      rd_strb = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int c0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 data", int'(data_out), 0);
      chk("R11 rdy", int'(data_rdy), 0);
      chk("R11 ovf", int'(overflow), 0);
      chk("R11 ferr", int'(frm_err), 0);
      chk("R11 par", int'(par_even), 0);
      rst_n = 1'b1;
      @(negedge clk);
      rx_mode = 3'b110;
      slot(1'b1);
      slot(1'b1);

      // R1/R2 vector walk
      for (int v = 0; v < 9; v++) begin
         c0 = rdy_cnt;
         send(VEC[v][20:18], VEC[v][17:10], VEC[v][9], 1'b1, 1'b1);
         slot(1'b1);
         chk("R1 data", int'(data_out), int'(VEC[v][8:1]));
         chk("R2 parity", int'(par_even), int'(VEC[v][0]));
         chk("R4 ferr clear", int'(frm_err), 0);
         chk("R9 one pulse", rdy_cnt - c0, 1);
         rd_pulse();
      end

      // R9 exact timing of the ready pulse
      rx_fmt = 3'b110;
      slot(1'b0);
      for (int i = 0; i < 8; i++) slot(((8'h5A >> i) & 8'h01) != 0);
      for (int i = 0; i < 4; i++) tick(1'b1);
      tick(1'b1);
      chk("R9 not yet", int'(data_rdy), 0);
      @(negedge clk);
      chk("R9 pulse", int'(data_rdy), 1);
      chk("R9 data", int'(data_out), 8'h5A);
      @(negedge clk);
      chk("R9 pulse ends", int'(data_rdy), 0);
      for (int i = 0; i < 3; i++) tick(1'b1);
      rd_pulse();

      // R3 glitch rejection
      c0 = rdy_cnt;
      for (int i = 0; i < 4; i++) tick(1'b0);
      slot(1'b1);
      slot(1'b1);
      slot(1'b1);
      chk("R3 glitch ignored", rdy_cnt - c0, 0);
      send(3'b110, 8'hC3, 1'b0, 1'b1, 1'b1);
      slot(1'b1);
      chk("R3 next char", int'(data_out), 8'hC3);
      rd_pulse();

      // R4 missing stop without overspeed
      c0 = rdy_cnt;
      send(3'b110, 8'h81, 1'b0, 1'b1, 1'b0);
      chk("R4 data kept", int'(data_out), 8'h81);
      chk("R4 ferr", int'(frm_err), 1);
      rd_pulse();
      send(3'b110, 8'h42, 1'b0, 1'b0, 1'b1);
      slot(1'b1);
      chk("R4 follow-on data", int'(data_out), 8'h42);
      chk("R4 follow-on ferr", int'(frm_err), 0);
      chk("R4 two bytes", rdy_cnt - c0, 2);
      rd_pulse();

      // R5 break
      send(3'b111, 8'h00, 1'b0, 1'b1, 1'b0);
      chk("R5 break ferr", int'(frm_err), 1);
      chk("R5 break data", int'(data_out), 0);
      rd_pulse();
      c0 = rdy_cnt;
      slot(1'b0);
      slot(1'b0);
      slot(1'b0);
      chk("R5 no resync while low", rdy_cnt - c0, 0);
      slot(1'b1);
      slot(1'b1);
      send(3'b111, 8'h3C, 1'b0, 1'b1, 1'b1);
      slot(1'b1);
      chk("R5 resync data", int'(data_out), 8'h3C);
      chk("R5 resync ferr", int'(frm_err), 0);
      rd_pulse();

      // R7 receiver off
      rx_mode = 3'b000;
      slot(1'b1);
      c0 = rdy_cnt;
      send(3'b110, 8'h99, 1'b0, 1'b1, 1'b1);
      slot(1'b1);
      chk("R7 no delivery", rdy_cnt - c0, 0);
      chk("R7 data held", int'(data_out), 8'h3C);

      // R6 wide tolerance (8)
      rx_mode = 3'b100;
      slot(1'b1);
      slot(1'b1);
      send(3'b110, 8'h11, 1'b0, 1'b1, 1'b0);
      chk("R6 wide first miss ok", int'(frm_err), 0);
      chk("R6 wide data", int'(data_out), 8'h11);
      rd_pulse();
      for (int j = 1; j <= 6; j++) begin
         send(3'b110, 8'(8'h20 + j), 1'b0, j != 1, 1'b1);
         chk("R6 wide normal", int'(frm_err), 0);
         rd_pulse();
      end
      send(3'b110, 8'h33, 1'b0, 1'b1, 1'b0);
      chk("R6 wide refused", int'(frm_err), 1);
      rd_pulse();
      send(3'b110, 8'h44, 1'b0, 1'b0, 1'b0);
      chk("R6 wide accepted again", int'(frm_err), 0);
      chk("R6 wide data2", int'(data_out), 8'h44);
      rd_pulse();
      send(3'b110, 8'h55, 1'b0, 1'b0, 1'b1);
      slot(1'b1);
      chk("R6 wide tail", int'(data_out), 8'h55);
      rd_pulse();

      // R6 narrow tolerance (16)
      rx_mode = 3'b101;
      slot(1'b1);
      slot(1'b1);
      send(3'b110, 8'h11, 1'b0, 1'b1, 1'b0);
      chk("R6 narrow first miss ok", int'(frm_err), 0);
      rd_pulse();
      for (int j = 1; j <= 14; j++) begin
         send(3'b110, 8'(j), 1'b0, j != 1, 1'b1);
         rd_pulse();
      end
      chk("R6 narrow normal", int'(frm_err), 0);
      send(3'b110, 8'h66, 1'b0, 1'b1, 1'b0);
      chk("R6 narrow refused", int'(frm_err), 1);
      rd_pulse();
      send(3'b110, 8'h77, 1'b0, 1'b0, 1'b0);
      chk("R6 narrow accepted again", int'(frm_err), 0);
      rd_pulse();
      send(3'b110, 8'h01, 1'b0, 1'b0, 1'b1);
      slot(1'b1);
      rd_pulse();

      // R10 overflow
      rx_mode = 3'b110;
      slot(1'b1);
      slot(1'b1);
      send(3'b110, 8'h11, 1'b0, 1'b1, 1'b1);
      chk("R10 no overflow yet", int'(overflow), 0);
      send(3'b110, 8'h22, 1'b0, 1'b1, 1'b1);
      slot(1'b1);
      chk("R10 overflow set", int'(overflow), 1);
      chk("R10 newest kept", int'(data_out), 8'h22);
      rd_pulse();
      chk("R10 read clears", int'(overflow), 0);

      // R8 synchronous mode
      @(negedge clk);
      rx_mode = 3'b111;
      for (int i = 0; i < 8; i++) slot(((8'hC6 >> i) & 8'h01) != 0);
      chk("R8 sync byte1", int'(data_out), 8'hC6);
      chk("R8 sync par1", int'(par_even), 1);
      chk("R8 sync ferr", int'(frm_err), 0);
      rd_pulse();
      for (int i = 0; i < 8; i++) slot(((8'h3B >> i) & 8'h01) != 0);
      chk("R8 sync byte2", int'(data_out), 8'h3B);
      chk("R8 sync par2", int'(par_even), 0);
      chk("R8 sync no overflow", int'(overflow), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule